// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by fetching two page-table entries from memory, one after the other. A request carries the virtual address, and the base of the root table comes from a separate input that is latched at the same moment. The walker uses the top ten address bits to index the root table. The entry found there names the 4 KiB frame that holds the second-level table. The middle ten bits index that table, and the entry found there names the data frame. The low twelve bits pass through to the result unchanged.

Both levels share one entry layout. Bits 31:12 hold the frame number and bit 0 is the valid flag. Bits 1 to 4 carry the read, write, execute and dirty flags, and the walker returns them without acting on them. If either entry has its valid flag clear, the walk stops and a fault is reported that names the failing level. On success the physical address comes out together with the full second-level entry, so that a translation cache can be filled from it.

Memory is reached through a simple port. A one-cycle read request carries a word address. Some cycles later a one-cycle response returns the data word. The walker accepts a new translation only while it is idle.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and `mem_req_valid`, `done_valid` and `fault_valid` are 0.
- R2: The first read goes to `root_base + vaddr[31:22]*4`, and `mem_req_valid` stays high for exactly one cycle per read.
- R3: The second read goes to `{entry1[31:12], 12'h000} + vaddr[21:12]*4`, where entry1 is the first word returned.
- R4: On success `done_valid` pulses for exactly one cycle, with `done_paddr = {entry2[31:12], vaddr[11:0]}`. The walker is then idle again.
- R5: With `done_valid`, `done_pte` equals the second word returned (entry2), including its flag bits.
- R6: If entry1 bit 0 is 0, `fault_valid` pulses for one cycle with `fault_cause = 2'b01`, and no second read is issued.
- R7: If entry1 is valid but entry2 bit 0 is 0, `fault_valid` pulses for one cycle with `fault_cause = 2'b10`, after exactly two reads.
- R8: Take a request sampled at a clock edge and a memory response L cycles after the request cycle. The result pulse is then visible 2L+3 cycles after the cycle in which `req_valid` was presented (L+2 cycles for a first-level fault), and `done_valid` and `fault_valid` are never high together.
- R9: `req_ready` is 0 from the cycle after acceptance until the walk ends. A `req_valid` raised during a walk is ignored and does not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request, sampled while `req_ready` is 1 |
| req_vaddr | input | 32 | Virtual address to translate |
| root_base | input | 32 | Byte address of the root table, latched with the request |
| req_ready | output | 1 | Walker idle and able to accept a request |
| mem_req_valid | output | 1 | One-cycle memory read request |
| mem_req_addr | output | 32 | Byte address of the entry being read |
| mem_rsp_valid | input | 1 | One-cycle memory response strobe |
| mem_rsp_data | input | 32 | Entry word returned by memory |
| done_valid | output | 1 | One-cycle pulse: translation finished |
| done_paddr | output | 32 | Translated physical address |
| done_pte | output | 32 | Second-level entry used for the translation |
| fault_valid | output | 1 | One-cycle pulse: walk stopped on an invalid entry |
| fault_cause | output | 2 | 01 = root-level entry invalid, 10 = second-level entry invalid |

## Verification
Inputs are driven and outputs sampled on the falling clock edge. Time is counted in falling edges from the cycle in which `req_valid` is presented. The bench memory model answers each read exactly L cycles after the request cycle, with L chosen per walk. For that reason each outcome is checked at an exact count: a successful walk or a second-level fault must appear at 2L+3, and a first-level fault at L+2. The falling edge after the pulse is checked for the pulse having dropped and the walker being ready again. Read addresses are captured by the memory model in the cycle the request is presented and compared against the addresses the bench computes from its own table contents.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD1,
    ST_WT1,
    ST_RD2,
    ST_WT2,
    ST_DONE,
    ST_FAULT
  } walk_state_t;

  localparam int unsigned ENTRY_VALID_BIT = 0;

  localparam logic [1:0] CAUSE_ROOT   = 2'b01;
  localparam logic [1:0] CAUSE_SECOND = 2'b10;

endpackage

// File: rtl/pt_walk_addr.sv
module pt_walk_addr #(
  parameter int unsigned VA_W       = 32,
  parameter int unsigned HI_W       = 10,
  parameter int unsigned MID_W      = 10,
  parameter int unsigned OFF_W      = 12,
  parameter int unsigned ENTRY_LOG2 = 2
) (
  input  logic [HI_W-1:0]       hi_idx,
  input  logic [VA_W-1:0]       root_base,
  input  logic [MID_W-1:0]      mid_idx,
  input  logic [OFF_W-1:0]      page_off,
  input  logic [VA_W-OFF_W-1:0] entry_frame,
  output logic [VA_W-1:0]       l1_addr,
  output logic [VA_W-1:0]       l2_addr,
  output logic [VA_W-1:0]       phys_addr
);

  localparam int unsigned PAD1 = VA_W - HI_W - ENTRY_LOG2;
  localparam int unsigned PAD2 = VA_W - MID_W - ENTRY_LOG2;

  logic [VA_W-1:0] frame_base;

  always_comb begin
    frame_base = {entry_frame, {OFF_W{1'b0}}};
    l1_addr    = root_base + {{PAD1{1'b0}}, hi_idx, {ENTRY_LOG2{1'b0}}};
    l2_addr    = frame_base + {{PAD2{1'b0}}, mid_idx, {ENTRY_LOG2{1'b0}}};
    phys_addr  = {entry_frame, page_off};
  end

endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
  import pt_walk_pkg::*;
#(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned MID_W = 10,
  parameter int unsigned OFF_W = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic [MID_W+OFF_W-1:0] req_low,
  input  logic [VA_W-1:0]        l1_addr,
  input  logic [VA_W-1:0]        l2_addr,
  input  logic [VA_W-1:0]        phys_addr,
  output logic [MID_W+OFF_W-1:0] cur_low,
  output logic                   req_ready,
  output logic                   mem_req_valid,
  output logic [VA_W-1:0]        mem_req_addr,
  input  logic                   mem_rsp_valid,
  input  logic [VA_W-1:0]        mem_rsp_data,
  output logic                   done_valid,
  output logic [VA_W-1:0]        done_paddr,
  output logic [VA_W-1:0]        done_pte,
  output logic                   fault_valid,
  output logic [1:0]             fault_cause
);

  walk_state_t state;
  logic        entry_ok;

  assign entry_ok = mem_rsp_data[ENTRY_VALID_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      cur_low      <= '0;
      mem_req_addr <= '0;
      done_paddr   <= '0;
      done_pte     <= '0;
      fault_cause  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            cur_low      <= req_low;
            mem_req_addr <= l1_addr;
            state        <= ST_RD1;
          end
        end
        ST_RD1: state <= ST_WT1;
        ST_WT1: begin
          if (mem_rsp_valid) begin
            if (!entry_ok) begin
              fault_cause <= CAUSE_ROOT;
              state       <= ST_FAULT;
            end else begin
              mem_req_addr <= l2_addr;
              state        <= ST_RD2;
            end
          end
        end
        ST_RD2: state <= ST_WT2;
        ST_WT2: begin
          if (mem_rsp_valid) begin
            if (!entry_ok) begin
              fault_cause <= CAUSE_SECOND;
              state       <= ST_FAULT;
            end else begin
              done_pte   <= mem_rsp_data;
              done_paddr <= phys_addr;
              state      <= ST_DONE;
            end
          end
        end
        ST_DONE:  state <= ST_IDLE;
        ST_FAULT: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (state == ST_IDLE);
  assign mem_req_valid = (state == ST_RD1) || (state == ST_RD2);
  assign done_valid    = (state == ST_DONE);
  assign fault_valid   = (state == ST_FAULT);

  a_r2_read_single_cycle: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |=> !mem_req_valid);

  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (req_ready && req_valid) |=> (!req_ready && mem_req_valid));

  a_r4_done_single_pulse: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> (!done_valid && req_ready));

  a_r5_pte_is_valid: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> done_pte[ENTRY_VALID_BIT]);

  a_r6_cause_one_level: assert property (@(posedge clk) disable iff (rst)
    fault_valid |-> ($countones(fault_cause) == 1));

  a_r7_fault_follows_response: assert property (@(posedge clk) disable iff (rst)
    fault_valid |-> $past(mem_rsp_valid));

  a_r8_outcomes_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(done_valid && fault_valid));

endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int unsigned VA_W       = 32,
  parameter int unsigned HI_W       = 10,
  parameter int unsigned MID_W      = 10,
  parameter int unsigned ENTRY_LOG2 = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic [VA_W-1:0] root_base,
  output logic            req_ready,
  output logic            mem_req_valid,
  output logic [VA_W-1:0] mem_req_addr,
  input  logic            mem_rsp_valid,
  input  logic [VA_W-1:0] mem_rsp_data,
  output logic            done_valid,
  output logic [VA_W-1:0] done_paddr,
  output logic [VA_W-1:0] done_pte,
  output logic            fault_valid,
  output logic [1:0]      fault_cause
);

  localparam int unsigned OFF_W = VA_W - HI_W - MID_W;
  localparam int unsigned LOW_W = MID_W + OFF_W;

  logic [LOW_W-1:0] cur_low;
  logic [VA_W-1:0]  l1_addr;
  logic [VA_W-1:0]  l2_addr;
  logic [VA_W-1:0]  phys_addr;

  pt_walk_addr #(
    .VA_W      (VA_W),
    .HI_W      (HI_W),
    .MID_W     (MID_W),
    .OFF_W     (OFF_W),
    .ENTRY_LOG2(ENTRY_LOG2)
  ) u_addr (
    .hi_idx     (req_vaddr[VA_W-1 -: HI_W]),
    .root_base  (root_base),
    .mid_idx    (cur_low[OFF_W +: MID_W]),
    .page_off   (cur_low[OFF_W-1:0]),
    .entry_frame(mem_rsp_data[VA_W-1:OFF_W]),
    .l1_addr    (l1_addr),
    .l2_addr    (l2_addr),
    .phys_addr  (phys_addr)
  );

  pt_walk_ctrl #(
    .VA_W (VA_W),
    .MID_W(MID_W),
    .OFF_W(OFF_W)
  ) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_low      (req_vaddr[LOW_W-1:0]),
    .l1_addr      (l1_addr),
    .l2_addr      (l2_addr),
    .phys_addr    (phys_addr),
    .cur_low      (cur_low),
    .req_ready    (req_ready),
    .mem_req_valid(mem_req_valid),
    .mem_req_addr (mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data (mem_rsp_data),
    .done_valid   (done_valid),
    .done_paddr   (done_paddr),
    .done_pte     (done_pte),
    .fault_valid  (fault_valid),
    .fault_cause  (fault_cause)
  );

endmodule

// File: tb/test_pt_walker.sv
module test_pt_walker;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [31:0] root_base = '0;
  logic        req_ready;
  logic        mem_req_valid;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        done_valid;
  logic [31:0] done_paddr;
  logic [31:0] done_pte;
  logic        fault_valid;
  logic [1:0]  fault_cause;

  int          checks = 0;
  int          fails = 0;
  logic        finished = 1'b0;

  logic [31:0] key = 32'h5a17c3e9;
  logic        force_l1_bad = 1'b0;
  logic        force_l2_bad = 1'b0;
  int          lat = 1;
  int          pend = 0;
  logic [31:0] pend_addr = '0;
  int          nreads = 0;
  logic [31:0] rd_addr0 = '0;
  logic [31:0] rd_addr1 = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker i_pt_walker (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .root_base(root_base), .req_ready(req_ready), .mem_req_valid(mem_req_valid),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done_valid(done_valid), .done_paddr(done_paddr),
    .done_pte(done_pte), .fault_valid(fault_valid), .fault_cause(fault_cause)
  );

  // Table contents: root-table words live where addr[31:28]==1, second-level
  // words elsewhere. Root entries point to frames with top nibble 2.
  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [31:0] h;
    logic [31:0] w;
    h = (a ^ key) * 32'h9e3779b1;
    h = h ^ (h >> 15);
    if (a[31:28] == 4'h1) begin
      w[31:12] = {4'h2, h[31:16]};
      w[11:1]  = h[11:1];
      w[0]     = force_l1_bad ? 1'b0 : (h[14:12] != 3'd0);
    end else begin
      w[31:12] = h[31:12];
      w[11:1]  = h[11:1];
      w[0]     = force_l2_bad ? 1'b0 : (h[14:12] != 3'd0);
    end
    return w;
  endfunction

  // Memory model: answers each read L cycles after the request cycle.
  always @(negedge clk) begin
    if (pend > 0) begin
      pend = pend - 1;
      if (pend == 0) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem_word(pend_addr);
      end else begin
        mem_rsp_valid <= 1'b0;
      end
    end else begin
      mem_rsp_valid <= 1'b0;
    end
    if (mem_req_valid) begin
      pend      = lat;
      pend_addr = mem_req_addr;
      if (nreads == 0) rd_addr0 = mem_req_addr;
      if (nreads == 1) rd_addr1 = mem_req_addr;
      nreads = nreads + 1;
    end
  end

  task automatic check(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_walk(input logic [31:0] va, input logic [31:0] root,
                          input int l, input logic poke);
    logic [31:0] e1, e2, a1, a2;
    int          exp_kind;
    int          exp_cyc;
    int          k;
    logic        got;
    a1 = root + {20'd0, va[31:22], 2'b00};
    e1 = mem_word(a1);
    a2 = {e1[31:12], 12'h000} + {20'd0, va[21:12], 2'b00};
    e2 = mem_word(a2);
    if (!e1[0]) begin exp_kind = 1; exp_cyc = l + 2; end
    else if (!e2[0]) begin exp_kind = 2; exp_cyc = 2*l + 3; end
    else begin exp_kind = 0; exp_cyc = 2*l + 3; end

    @(negedge clk);
    check(req_ready, "R9 ready before request", {63'd0, req_ready}, 64'd1);
    lat = l;
    nreads = 0;
    req_valid = 1'b1;
    req_vaddr = va;
    root_base = root;
    k = 0;
    got = 1'b0;
    while (!got && k < 60) begin
      @(negedge clk);
      k++;
      if (k == 1) req_valid = 1'b0;
      if (poke && k == 2) begin
        check(!req_ready, "R9 busy during walk", {63'd0, req_ready}, 64'd0);
        req_valid = 1'b1;
        req_vaddr = ~va;
        root_base = root ^ 32'h0000_5000;
      end
      if (poke && k == 3) req_valid = 1'b0;
      if (done_valid || fault_valid) got = 1'b1;
    end
    req_valid = 1'b0;
    check(got, "R8 walk finished", {63'd0, got}, 64'd1);
    check(k == exp_cyc, "R8 result latency", 64'(k), 64'(exp_cyc));
    check(!(done_valid && fault_valid), "R8 exclusive outcome",
          {62'd0, done_valid, fault_valid}, 64'd0);
    check(rd_addr0 == a1, "R2 first read address", {32'd0, rd_addr0}, {32'd0, a1});
    if (exp_kind == 1) begin
      check(fault_valid && fault_cause == 2'b01, "R6 root fault cause",
            {61'd0, fault_valid, fault_cause}, 64'h5);
      check(nreads == 1, "R6 single read", 64'(nreads), 64'd1);
    end else begin
      check(rd_addr1 == a2, "R3 second read address", {32'd0, rd_addr1}, {32'd0, a2});
      check(nreads == 2, "R3 two reads", 64'(nreads), 64'd2);
      if (exp_kind == 2) begin
        check(fault_valid && fault_cause == 2'b10, "R7 second fault cause",
              {61'd0, fault_valid, fault_cause}, 64'h6);
      end else begin
        check(done_valid && done_paddr == {e2[31:12], va[11:0]}, "R4 physical address",
              {31'd0, done_valid, done_paddr}, {31'd0, 1'b1, e2[31:12], va[11:0]});
        check(done_pte == e2, "R5 second entry", {32'd0, done_pte}, {32'd0, e2});
      end
    end
    @(negedge clk);
    check(!done_valid && !fault_valid && req_ready, "R4 pulse ends, idle again",
          {61'd0, done_valid, fault_valid, req_ready}, 64'd1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog actual=expired expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(req_ready && !mem_req_valid && !done_valid && !fault_valid, "R1 reset state",
          {60'd0, req_ready, mem_req_valid, done_valid, fault_valid}, 64'h8);

    // Directed corners
    run_walk(32'h0000_0000, 32'h1000_0000, 1, 1'b0);
    run_walk(32'hffff_ffff, 32'h1fff_0000, 2, 1'b0);
    force_l1_bad = 1'b1;
    run_walk(32'h1234_5678, 32'h1234_5000, 1, 1'b0);
    run_walk(32'h89ab_cdef, 32'h1234_5000, 3, 1'b1);
    force_l1_bad = 1'b0;
    force_l2_bad = 1'b1;
    run_walk(32'h1234_5678, 32'h1234_5000, 2, 1'b0);
    run_walk(32'h0040_1abc, 32'h1800_0000, 1, 1'b1);
    force_l2_bad = 1'b0;
    run_walk(32'hdead_beef, 32'h1abc_d000, 4, 1'b1);

    // Constrained random walks
    for (int i = 0; i < 60; i++) begin
      key = $urandom;
      run_walk($urandom, {4'h1, 16'($urandom), 12'h000}, 1 + int'($urandom % 3),
               ($urandom % 4) == 0);
    end
    finish_run();
  end

endmodule